// File: doc/BRIEF.md
# Two-Thread Gshare Direction Predictor

This block predicts the direction of conditional branches for a core that interleaves two hardware threads. Each thread has its own global history of resolved branch outcomes. A table of 2-bit saturating counters is indexed by the word-aligned fetch address XORed with the history of the thread that asks. By default one table serves both threads. A parameter can give each thread a private table instead.

The front end drives the lookup side with a thread number and a fetch PC. It receives a taken or not-taken guess in the same cycle, because the read is combinational. When the branch resolves, the back end drives the training side with the thread number, the branch PC and the real outcome. On the next clock edge the addressed counter moves one step toward that outcome, and the thread's history takes the outcome in at its low end. Target prediction, return address stacking and history repair after a wrong guess are handled elsewhere.

Top module: `bp_gshare_mt`

## Requirements
- R1: After reset every counter holds CTR_INIT (default 1) and both histories are zero, so every lookup on either thread predicts not taken.
- R2: `lk_taken` is high exactly when the selected counter is 2 or 3. Counter values 0 and 1 predict not taken.
- R3: A training request with `up_taken`=1 raises the addressed counter by one, and it stays at 3 once it reaches 3.
- R4: A training request with `up_taken`=0 lowers the addressed counter by one, and it stays at 0 once it reaches 0.
- R5: The counter index is `pc[HIST_W+1:2]` XOR the thread's history (HIST_W bits, default 10, which gives 2^HIST_W counters). PC bits 1:0 have no effect on the index.
- R6: A training request replaces the named thread's history with `{old[HIST_W-2:0], up_taken}`, where 1 means taken. The index used for that request is the one formed from the old history.
- R7: A training request leaves the other thread's history unchanged.
- R8: With PER_THREAD_TBL=0 both threads share one table, so a counter trained by thread 0 is seen by thread 1 whenever the two index values match.
- R9: With PER_THREAD_TBL=1 each thread reads and trains only its own table, and training by thread 0 never changes what thread 1 predicts.
- R10: If a lookup and a training request address the same counter in the same cycle, the lookup returns the counter value from before the training.
- R11: While `up_valid` is low, no counter and no history changes, whatever the other training inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_tid | input | TID_W | Thread issuing the lookup |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Training request present this cycle |
| up_tid | input | TID_W | Thread whose branch resolved |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives a run of fourteen taken outcomes so that the history saturates at all ones and one counter receives more increments than it can hold. A counter that wraps instead of saturating would then predict not taken. Two not-taken outcomes at history zero catch a counter that wraps from 0 to 3. A taken, not-taken, taken pattern is followed by a lookup at an offset PC, which exposes a history that shifts the wrong way or puts the outcome in the wrong bit. A second instance with private tables shows whether training leaks from one thread into the other's prediction. A lookup that coincides with training of the same counter, and training inputs held while `up_valid` is low, show whether the design forwards new values or takes in requests it should ignore.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX = 2'd3;
  localparam ctr_t CTR_MIN = 2'd0;

  // One saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken && (cur != CTR_MAX)) begin
      res = cur + 2'd1;
    end else if (!taken && (cur != CTR_MIN)) begin
      res = cur - 2'd1;
    end else begin
      res = cur;
    end
    return res;
  endfunction

  // Upper half of the counter range means taken.
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;

  always_comb begin
    hist_nxt = hist_q;
    if (upd_en) begin
      hist_nxt = {hist_q[HIST_W-2:0], upd_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (upd_en) begin
      hist_q <= hist_nxt;
    end
  end

  assign hist = hist_q;

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])) && (hist[0] == $past(upd_taken))); // R6

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(hist)); // R11

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int   IDX_W    = 10,
  parameter ctr_t CTR_INIT = 2'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_cur;
  ctr_t wr_nxt;

  always_comb begin
    wr_cur = ctr_q[wr_idx];
    wr_nxt = ctr_step(wr_cur, wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctr_q[i] <= CTR_INIT;
      end
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_nxt;
    end
  end

  // Combinational read: a same-cycle write lands only at the edge.
  assign rd_ctr = ctr_q[rd_idx];

  AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && (wr_cur == CTR_MAX)) |=> (ctr_q[$past(wr_idx)] == CTR_MAX)); // R3

  AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && (wr_cur == CTR_MIN)) |=> (ctr_q[$past(wr_idx)] == CTR_MIN)); // R4

  AST_CTR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && (wr_cur != CTR_MAX)) |=> (ctr_q[$past(wr_idx)] == $past(wr_cur) + 2'd1)); // R3

  AST_CTR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && (wr_cur != CTR_MIN)) |=> (ctr_q[$past(wr_idx)] == $past(wr_cur) - 2'd1)); // R4

endmodule

// File: rtl/bp_gshare_mt.sv
module bp_gshare_mt
  import bp_pkg::*;
#(
  parameter int   NUM_THR        = 2,
  parameter int   HIST_W         = 10,
  parameter int   PC_W           = 32,
  parameter bit   PER_THREAD_TBL = 1'b0,
  parameter ctr_t CTR_INIT       = 2'd1,
  localparam int  TID_W          = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] lk_tid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  input  logic             up_valid,
  input  logic [TID_W-1:0] up_tid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_taken
);

  localparam int PC_LSB = 2;
  localparam int PC_MSB = HIST_W + PC_LSB - 1;

  logic [NUM_THR-1:0][HIST_W-1:0] hist_all;
  logic [HIST_W-1:0]              lk_hist;
  logic [HIST_W-1:0]              up_hist;
  logic [HIST_W-1:0]              lk_idx;
  logic [HIST_W-1:0]              up_idx;
  ctr_t                           bank_ctr [NUM_THR];
  ctr_t                           lk_ctr;

  // Per-thread history registers.
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic thr_upd;
    assign thr_upd = up_valid && (up_tid == TID_W'(t));

    bp_hist_reg #(
      .HIST_W (HIST_W)
    ) i_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (thr_upd),
      .upd_taken (up_taken),
      .hist      (hist_all[t])
    );

    AST_OTHER_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && (up_tid != TID_W'(t))) |=> $stable(hist_all[t])); // R7
  end

  always_comb begin
    lk_hist = hist_all[lk_tid];
    up_hist = hist_all[up_tid];
    lk_idx  = lk_pc[PC_MSB:PC_LSB] ^ lk_hist;
    up_idx  = up_pc[PC_MSB:PC_LSB] ^ up_hist;
  end

  // Counter storage: one shared bank, or one bank per thread.
  for (genvar b = 0; b < NUM_THR; b++) begin : g_bank
    if (PER_THREAD_TBL || (b == 0)) begin : g_real
      logic bank_wr;
      assign bank_wr = up_valid && (!PER_THREAD_TBL || (up_tid == TID_W'(b)));

      bp_pht #(
        .IDX_W    (HIST_W),
        .CTR_INIT (CTR_INIT)
      ) i_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (bank_ctr[b]),
        .wr_en    (bank_wr),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
      );
    end else begin : g_alias
      assign bank_ctr[b] = bank_ctr[0];
    end
  end

  always_comb begin
    if (PER_THREAD_TBL) begin
      lk_ctr = bank_ctr[lk_tid];
    end else begin
      lk_ctr = bank_ctr[0];
    end
    lk_taken = ctr_dir(lk_ctr);
  end

  AST_RESET_NT: assert property (@(posedge clk)
    $rose(rst_n) |-> !lk_taken); // R1

endmodule

// File: tb/test_bp_gshare_mt.sv
module test_bp_gshare_mt;

  localparam int CLK_PERIOD = 10;
  localparam int HW = 10;
  localparam int DEPTH = 1 << HW;

  logic        clk;
  logic        rst_n;
  logic        lk_tid;
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic        lk_taken_s;
  logic        up_valid;
  logic        up_tid;
  logic [31:0] up_pc;
  logic        up_taken;

  int n_chk  = 0;
  int n_fail = 0;

  logic [HW-1:0] m_hist [2];
  logic [1:0]    m_tbl  [DEPTH];

  bp_gshare_mt #(.NUM_THR(2), .HIST_W(HW), .PC_W(32), .PER_THREAD_TBL(1'b0), .CTR_INIT(2'd1))
  i_bp_gshare_mt (
    .clk(clk), .rst_n(rst_n), .lk_tid(lk_tid), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_tid(up_tid), .up_pc(up_pc), .up_taken(up_taken));

  bp_gshare_mt #(.NUM_THR(2), .HIST_W(HW), .PC_W(32), .PER_THREAD_TBL(1'b1), .CTR_INIT(2'd1))
  i_bp_gshare_mt_split (
    .clk(clk), .rst_n(rst_n), .lk_tid(lk_tid), .lk_pc(lk_pc), .lk_taken(lk_taken_s),
    .up_valid(up_valid), .up_tid(up_tid), .up_pc(up_pc), .up_taken(up_taken));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {tid, pc, outcome}
  localparam logic [33:0] VEC [16] = '{
    {1'b0, 32'h0000_1000, 1'b1}, {1'b0, 32'h0000_1000, 1'b1},
    {1'b1, 32'h0000_1000, 1'b1}, {1'b0, 32'h0000_1004, 1'b0},
    {1'b1, 32'h0000_2F40, 1'b1}, {1'b1, 32'h0000_2F40, 1'b1},
    {1'b0, 32'h0000_1000, 1'b1}, {1'b1, 32'h0000_1004, 1'b0},
    {1'b0, 32'h0000_3ABC, 1'b1}, {1'b0, 32'h0000_3ABC, 1'b0},
    {1'b1, 32'h0000_2F40, 1'b1}, {1'b0, 32'h0000_1000, 1'b1},
    {1'b1, 32'h0000_0FFC, 1'b0}, {1'b0, 32'h0000_0FFC, 1'b1},
    {1'b1, 32'h0000_2F40, 1'b1}, {1'b0, 32'h0000_1004, 1'b1}
  };

  function automatic logic [HW-1:0] m_idx(input logic t, input logic [31:0] pc);
    return pc[HW+1:2] ^ m_hist[t];
  endfunction

  function automatic logic m_pred(input logic t, input logic [31:0] pc);
    return m_tbl[m_idx(t, pc)] >= 2'd2;
  endfunction

  task automatic m_upd(input logic t, input logic [31:0] pc, input logic tk);
    logic [HW-1:0] ix;
    ix = m_idx(t, pc);
    if (tk && m_tbl[ix] != 2'd3) m_tbl[ix] = m_tbl[ix] + 2'd1;
    else if (!tk && m_tbl[ix] != 2'd0) m_tbl[ix] = m_tbl[ix] - 2'd1;
    m_hist[t] = {m_hist[t][HW-2:0], tk};
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic look(input logic t, input logic [31:0] pc);
    @(negedge clk);
    lk_tid = t;
    lk_pc  = pc;
    #1;
  endtask

  task automatic upd(input logic t, input logic [31:0] pc, input logic tk);
    @(negedge clk);
    up_valid = 1'b1;
    up_tid   = t;
    up_pc    = pc;
    up_taken = tk;
    @(negedge clk);
    up_valid = 1'b0;
    m_upd(t, pc, tk);
  endtask

  task automatic do_reset();
    up_valid = 1'b0;
    rst_n    = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_tbl[i] = 2'd1;
    m_hist[0] = '0;
    m_hist[1] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    lk_tid = 1'b0; lk_pc = '0; up_tid = 1'b0; up_pc = '0; up_taken = 1'b0;
    do_reset();

    // R1: reset state on both threads and both table variants
    look(1'b0, 32'h0000_1000); chk("R1 t0", lk_taken, 1'b0);
    look(1'b1, 32'h0000_2F40); chk("R1 t1", lk_taken, 1'b0);
    look(1'b1, 32'h0000_0FFC); chk("R1 split", lk_taken_s, 1'b0);

    // R2 R5 R6 R8: vector walk against the bench model (shared table)
    for (int v = 0; v < 16; v++) begin
      look(VEC[v][33], VEC[v][32:1]);
      chk("R2/R5 walk", lk_taken, m_pred(VEC[v][33], VEC[v][32:1]));
      upd(VEC[v][33], VEC[v][32:1], VEC[v][0]);
    end
    look(1'b0, 32'h0000_1000); chk("R6 walk end t0", lk_taken, m_pred(1'b0, 32'h0000_1000));
    look(1'b1, 32'h0000_2F40); chk("R6 walk end t1", lk_taken, m_pred(1'b1, 32'h0000_2F40));

    // R4: two not-taken at zero history; a wrap to 3 would predict taken
    do_reset();
    upd(1'b0, 32'h0000_0040, 1'b0);
    upd(1'b0, 32'h0000_0040, 1'b0);
    look(1'b0, 32'h0000_0040); chk("R4 floor", lk_taken, 1'b0);

    // R3: fourteen taken, history saturates at ones, counter must hold at 3
    do_reset();
    for (int k = 0; k < 14; k++) upd(1'b0, 32'h0000_2A8C, 1'b1);
    look(1'b0, 32'h0000_2A8C); chk("R3 ceiling", lk_taken, 1'b1);
    look(1'b0, 32'h0000_2A8F); chk("R5 low PC bits", lk_taken, 1'b1);
    // R8: thread 1 (history 0) reaches the same counter through pc ^ (ones<<2)
    look(1'b1, 32'h0000_2A8C ^ 32'h0000_0FFC); chk("R8 shared", lk_taken, 1'b1);
    chk("R9 split t1", lk_taken_s, 1'b0);
    look(1'b0, 32'h0000_2A8C); chk("R9 split t0", lk_taken_s, 1'b1);
    // R7: thread 1 trains; thread 0 history must stay all ones
    upd(1'b1, 32'h0000_0100, 1'b0);
    look(1'b0, 32'h0000_2A8C); chk("R7 other thread", lk_taken, 1'b1);

    // R6: T,N,T on thread 1 gives history 101
    do_reset();
    upd(1'b1, 32'h0000_0800, 1'b1);
    upd(1'b1, 32'h0000_0800, 1'b0);
    upd(1'b1, 32'h0000_0800, 1'b1);
    look(1'b1, 32'h0000_0800 ^ (32'd5 << 2)); chk("R6 shift order", lk_taken, 1'b1);

    // R10: same-cycle lookup and training of one counter
    do_reset();
    @(negedge clk);
    lk_tid = 1'b0; lk_pc = 32'h0000_0300;
    up_valid = 1'b1; up_tid = 1'b0; up_pc = 32'h0000_0300; up_taken = 1'b1;
    #1;
    chk("R10 old value", lk_taken, 1'b0);
    @(negedge clk);
    up_valid = 1'b0;
    m_upd(1'b0, 32'h0000_0300, 1'b1);
    look(1'b0, 32'h0000_0304); chk("R10 write landed", lk_taken, 1'b1);

    // R11: training inputs held with up_valid low
    do_reset();
    @(negedge clk);
    up_tid = 1'b0; up_pc = 32'h0000_0300; up_taken = 1'b1;
    repeat (4) @(negedge clk);
    look(1'b0, 32'h0000_0300 ^ (32'hF << 2)); chk("R11 history idle", lk_taken, 1'b0);
    look(1'b0, 32'h0000_0300); chk("R11 counter idle", lk_taken, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule